// File: doc/BRIEF.md
# Clustered Operand Bypass Network

This block chooses the value that each ALU input of an in-order, multi-issue execution backend consumes. The ALUs are split into clusters of equal size. A consumer operand can take its value from a result that leaves execute in the same cycle, from a result in the writeback stage, from a result produced in another cluster, or from the register-file read value. Results move freely between the ALUs of one cluster with no added delay. A result from another cluster only becomes usable after it has passed through a fixed number of delay registers. This keeps the per-ALU selection narrow and removes the long cross-cluster wires from the single-cycle forward-and-execute loop.

Each operand brings a source tag and the value read from the register file. The block returns the selected 64-bit value and a not-ready flag that the issue stall logic uses. The register write runs in parallel with forwarding, so the register-file input is assumed to hold every result older than the forwarding window. ALU `a` belongs to cluster `a / (N/K)`. Operand `p` of ALU `a` is operand index `a*NSRC + p`. Within one pipeline stage, a higher ALU index is the younger instruction in program order.

Top module: `clustered_bypass`

## Requirements
- R1: After reset the cross-cluster delay registers hold nothing. With no valid producers, every operand returns its register-file value and not-ready is 0.
- R2: A valid execute-stage result from the operand's own cluster whose tag matches is forwarded in the same cycle, with not-ready 0. It has priority over every other source.
- R3: When several producers of one source kind and stage match the same tag, the one with the highest ALU index supplies the value.
- R4: With no local execute match, a valid matching writeback-stage result of the operand's own cluster is forwarded, with not-ready 0.
- R5: A valid matching execute-stage result in another cluster, with no local execute match, sets not-ready to 1. This beats a local writeback match. While not-ready is 1, the operand data equals the register-file value.
- R6: A result that leaves execute in another cluster in cycle t is forwarded in cycle t+XDELAY (default 2). In cycles between t+1 and t+XDELAY-1 it gives not-ready 1. From cycle t+XDELAY+1 on, it is no longer a source.
- R7: An operand whose tag matches no valid producer returns its register-file value with not-ready 0.
- R8: A local writeback result beats a matching remote result of the same age that is still in the delay registers.
- R9: Producers with their valid bit at 0 have no effect, both in the current cycle and in later cycles through the delay registers.
- R10: A cluster takes its own results only from its execute and writeback ports, never through the delay registers. Writeback ports of other clusters are not a source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_vld | input | N | Result valid at end of execute, per ALU |
| ex_tag | input | N x TAG_W | Destination register tag of execute result |
| ex_data | input | N x DATA_W | Execute result value |
| wb_vld | input | N | Writeback-stage result valid, per ALU |
| wb_tag | input | N x TAG_W | Destination tag of writeback result |
| wb_data | input | N x DATA_W | Writeback result value |
| src_tag | input | N*NSRC x TAG_W | Source register tag per operand |
| rf_data | input | N*NSRC x DATA_W | Register-file read value per operand |
| opnd_data | output | N*NSRC x DATA_W | Selected operand value |
| opnd_nrdy | output | N*NSRC | Operand value not yet reachable; stall |

## Verification
The only state in the block is the cross-cluster delay line. A wrong entry, a wrong depth or a failure to clear it shows up at the ports as a remote value that appears one cycle early or late. It can also show as a stall that never releases, or as a stale value that overrides the register file one or two cycles after the producer has left. Selection faults are combinational and appear in the same cycle as the stimulus. For this reason the directed cases sample every cycle of the delay window, and the scoreboard compares all operands every cycle against a model built from the age ordering.

// File: rtl/cbyp_pkg.sv
package cbyp_pkg;

    // Source chosen for one operand
    typedef enum logic [2:0] {
        SEL_RF   = 3'd0,
        SEL_LEX  = 3'd1,
        SEL_LWB  = 3'd2,
        SEL_RMT  = 3'd3,
        SEL_WAIT = 3'd4
    } sel_e;

endpackage

// File: rtl/cbyp_xdelay.sv
// Delay line for execute results on their way to other clusters.
module cbyp_xdelay #(
    parameter int N      = 4,
    parameter int TAG_W  = 5,
    parameter int DATA_W = 64,
    parameter int XDELAY = 2
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic [N-1:0]                            ex_vld,
    input  logic [N-1:0][TAG_W-1:0]                 ex_tag,
    input  logic [N-1:0][DATA_W-1:0]                ex_data,
    output logic [XDELAY-1:0][N-1:0]                st_vld,
    output logic [XDELAY-1:0][N-1:0][TAG_W-1:0]     st_tag,
    output logic [XDELAY-1:0][N-1:0][DATA_W-1:0]    st_data
);

    typedef struct packed {
        logic [XDELAY-1:0][N-1:0]                   vld;
        logic [XDELAY-1:0][N-1:0][TAG_W-1:0]        tag;
        logic [XDELAY-1:0][N-1:0][DATA_W-1:0]       data;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d = pipe_q;
        pipe_d.vld[0] = ex_vld;
        pipe_d.tag[0] = ex_tag;
        for (int j = 0; j < N; j++) begin
            // hold data of empty slots to save toggles
            pipe_d.data[0][j] = ex_vld[j] ? ex_data[j] : pipe_q.data[0][j];
        end
        for (int s = 1; s < XDELAY; s++) begin
            pipe_d.vld[s]  = pipe_q.vld[s-1];
            pipe_d.tag[s]  = pipe_q.tag[s-1];
            pipe_d.data[s] = pipe_q.data[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign st_vld  = pipe_q.vld;
    assign st_tag  = pipe_q.tag;
    assign st_data = pipe_q.data;

endmodule

// File: rtl/cbyp_opnd_sel.sv
// Source selection for one ALU operand.
module cbyp_opnd_sel
    import cbyp_pkg::*;
#(
    parameter int LPC    = 2,
    parameter int RN     = 2,
    parameter int TAG_W  = 5,
    parameter int DATA_W = 64,
    parameter int XDELAY = 2
) (
    input  logic [LPC-1:0]                          lex_vld,
    input  logic [LPC-1:0][TAG_W-1:0]               lex_tag,
    input  logic [LPC-1:0][DATA_W-1:0]              lex_data,
    input  logic [LPC-1:0]                          lwb_vld,
    input  logic [LPC-1:0][TAG_W-1:0]               lwb_tag,
    input  logic [LPC-1:0][DATA_W-1:0]              lwb_data,
    input  logic [RN-1:0]                           rex_vld,
    input  logic [RN-1:0][TAG_W-1:0]                rex_tag,
    input  logic [XDELAY-1:0][RN-1:0]               rst_vld,
    input  logic [XDELAY-1:0][RN-1:0][TAG_W-1:0]    rst_tag,
    input  logic [XDELAY-1:0][RN-1:0][DATA_W-1:0]   rst_data,
    input  logic [TAG_W-1:0]                        src_tag,
    input  logic [DATA_W-1:0]                       rf_data,
    output logic [DATA_W-1:0]                       opnd_data,
    output logic                                    opnd_nrdy
);

    logic              lex_hit, lwb_hit, rex_hit, rst_hit, stg_hit;
    logic [DATA_W-1:0] lex_val, lwb_val, rst_val, stg_val;
    int                rst_stage;
    sel_e              sel;

    always_comb begin
        // local execute: higher index is younger, so later match overrides
        lex_hit = 1'b0;
        lex_val = '0;
        for (int i = 0; i < LPC; i++) begin
            if (lex_vld[i] && lex_tag[i] == src_tag) begin
                lex_hit = 1'b1;
                lex_val = lex_data[i];
            end
        end

        // local writeback
        lwb_hit = 1'b0;
        lwb_val = '0;
        for (int i = 0; i < LPC; i++) begin
            if (lwb_vld[i] && lwb_tag[i] == src_tag) begin
                lwb_hit = 1'b1;
                lwb_val = lwb_data[i];
            end
        end

        // remote execute: visible only after the delay line
        rex_hit = 1'b0;
        for (int r = 0; r < RN; r++) begin
            if (rex_vld[r] && rex_tag[r] == src_tag) begin
                rex_hit = 1'b1;
            end
        end

        // delay line: scan oldest stage first so the youngest wins
        rst_hit   = 1'b0;
        rst_val   = '0;
        rst_stage = 0;
        for (int s = XDELAY - 1; s >= 0; s--) begin
            stg_hit = 1'b0;
            stg_val = '0;
            for (int r = 0; r < RN; r++) begin
                if (rst_vld[s][r] && rst_tag[s][r] == src_tag) begin
                    stg_hit = 1'b1;
                    stg_val = rst_data[s][r];
                end
            end
            if (stg_hit) begin
                rst_hit   = 1'b1;
                rst_val   = stg_val;
                rst_stage = s;
            end
        end

        // age order: execute stage, then writeback age, then older stages
        if (lex_hit) begin
            sel = SEL_LEX;
        end else if (rex_hit) begin
            sel = SEL_WAIT;
        end else if (lwb_hit) begin
            sel = SEL_LWB;
        end else if (rst_hit) begin
            sel = (rst_stage == XDELAY - 1) ? SEL_RMT : SEL_WAIT;
        end else begin
            sel = SEL_RF;
        end

        opnd_nrdy = (sel == SEL_WAIT);
        case (sel)
            SEL_LEX: opnd_data = lex_val;
            SEL_LWB: opnd_data = lwb_val;
            SEL_RMT: opnd_data = rst_val;
            default: opnd_data = rf_data;
        endcase
    end

endmodule

// File: rtl/clustered_bypass.sv
// Operand bypass network for a clustered multi-issue backend.
module clustered_bypass #(
    parameter int N      = 4,
    parameter int K      = 2,
    parameter int NSRC   = 2,
    parameter int TAG_W  = 5,
    parameter int DATA_W = 64,
    parameter int XDELAY = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [N-1:0]                        ex_vld,
    input  logic [N-1:0][TAG_W-1:0]             ex_tag,
    input  logic [N-1:0][DATA_W-1:0]            ex_data,
    input  logic [N-1:0]                        wb_vld,
    input  logic [N-1:0][TAG_W-1:0]             wb_tag,
    input  logic [N-1:0][DATA_W-1:0]            wb_data,
    input  logic [N*NSRC-1:0][TAG_W-1:0]        src_tag,
    input  logic [N*NSRC-1:0][DATA_W-1:0]       rf_data,
    output logic [N*NSRC-1:0][DATA_W-1:0]       opnd_data,
    output logic [N*NSRC-1:0]                   opnd_nrdy
);

    localparam int LPC = N / K;     // ALUs per cluster
    localparam int RN  = N - LPC;   // producers outside a cluster

    logic [XDELAY-1:0][N-1:0]               st_vld;
    logic [XDELAY-1:0][N-1:0][TAG_W-1:0]    st_tag;
    logic [XDELAY-1:0][N-1:0][DATA_W-1:0]   st_data;

    cbyp_xdelay #(
        .N(N), .TAG_W(TAG_W), .DATA_W(DATA_W), .XDELAY(XDELAY)
    ) u_xdelay (
        .clk     (clk),
        .rst_n   (rst_n),
        .ex_vld  (ex_vld),
        .ex_tag  (ex_tag),
        .ex_data (ex_data),
        .st_vld  (st_vld),
        .st_tag  (st_tag),
        .st_data (st_data)
    );

    for (genvar c = 0; c < K; c++) begin : g_cl
        logic [RN-1:0]                          rex_vld;
        logic [RN-1:0][TAG_W-1:0]               rex_tag;
        logic [XDELAY-1:0][RN-1:0]              rst_vld;
        logic [XDELAY-1:0][RN-1:0][TAG_W-1:0]   rst_tag;
        logic [XDELAY-1:0][RN-1:0][DATA_W-1:0]  rst_data;

        // gather producers of every other cluster, keeping index order
        for (genvar r = 0; r < RN; r++) begin : g_rm
            localparam int J = (r < c * LPC) ? r : r + LPC;
            assign rex_vld[r] = ex_vld[J];
            assign rex_tag[r] = ex_tag[J];
            for (genvar s = 0; s < XDELAY; s++) begin : g_st
                assign rst_vld[s][r]  = st_vld[s][J];
                assign rst_tag[s][r]  = st_tag[s][J];
                assign rst_data[s][r] = st_data[s][J];
            end
        end

        for (genvar a = 0; a < LPC; a++) begin : g_alu
            for (genvar p = 0; p < NSRC; p++) begin : g_src
                localparam int OP = (c * LPC + a) * NSRC + p;
                cbyp_opnd_sel #(
                    .LPC(LPC), .RN(RN), .TAG_W(TAG_W),
                    .DATA_W(DATA_W), .XDELAY(XDELAY)
                ) u_sel (
                    .lex_vld   (ex_vld[c*LPC +: LPC]),
                    .lex_tag   (ex_tag[c*LPC +: LPC]),
                    .lex_data  (ex_data[c*LPC +: LPC]),
                    .lwb_vld   (wb_vld[c*LPC +: LPC]),
                    .lwb_tag   (wb_tag[c*LPC +: LPC]),
                    .lwb_data  (wb_data[c*LPC +: LPC]),
                    .rex_vld   (rex_vld),
                    .rex_tag   (rex_tag),
                    .rst_vld   (rst_vld),
                    .rst_tag   (rst_tag),
                    .rst_data  (rst_data),
                    .src_tag   (src_tag[OP]),
                    .rf_data   (rf_data[OP]),
                    .opnd_data (opnd_data[OP]),
                    .opnd_nrdy (opnd_nrdy[OP])
                );
            end
        end
    end

endmodule

// File: rtl/clustered_bypass_chk.sv
module clustered_bypass_chk #(
    parameter int N      = 4,
    parameter int K      = 2,
    parameter int NSRC   = 2,
    parameter int TAG_W  = 5,
    parameter int DATA_W = 64,
    parameter int XDELAY = 2
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [N-1:0]                     ex_vld,
    input logic [N-1:0][TAG_W-1:0]          ex_tag,
    input logic [N-1:0]                     wb_vld,
    input logic [N*NSRC-1:0][TAG_W-1:0]     src_tag,
    input logic [N*NSRC-1:0][DATA_W-1:0]    rf_data,
    input logic [N*NSRC-1:0][DATA_W-1:0]    opnd_data,
    input logic [N*NSRC-1:0]                opnd_nrdy
);

    localparam int LPC = N / K;
    localparam int OPS = N * NSRC;
    localparam int CW  = $clog2(XDELAY + 1) + 1;

    logic [OPS-1:0] lex_any, rex_any;
    logic [CW-1:0]  quiet_q;

    always_comb begin
        lex_any = '0;
        rex_any = '0;
        for (int o = 0; o < OPS; o++) begin
            for (int j = 0; j < N; j++) begin
                if (ex_vld[j] && ex_tag[j] == src_tag[o]) begin
                    if (j / LPC == (o / NSRC) / LPC) lex_any[o] = 1'b1;
                    else                             rex_any[o] = 1'b1;
                end
            end
        end
    end

    // cycles since the last valid execute result, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)                        quiet_q <= CW'(XDELAY);
        else if (|ex_vld)                  quiet_q <= '0;
        else if (quiet_q < CW'(XDELAY))    quiet_q <= quiet_q + 1'b1;
    end

    for (genvar o = 0; o < OPS; o++) begin : g_op
        // R2
        lex_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lex_any[o] |-> !opnd_nrdy[o]);

        // R5
        rex_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!lex_any[o] && rex_any[o]) |-> opnd_nrdy[o]);

        // R5
        stall_rf_chk: assert property (@(posedge clk) disable iff (!rst_n)
            opnd_nrdy[o] |-> (opnd_data[o] == rf_data[o]));

        // R1
        quiet_rf_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (quiet_q >= CW'(XDELAY) && ex_vld == '0 && wb_vld == '0)
            |-> (!opnd_nrdy[o] && opnd_data[o] == rf_data[o]));
    end

endmodule

bind clustered_bypass clustered_bypass_chk #(
    .N(N), .K(K), .NSRC(NSRC), .TAG_W(TAG_W), .DATA_W(DATA_W), .XDELAY(XDELAY)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ex_vld    (ex_vld),
    .ex_tag    (ex_tag),
    .wb_vld    (wb_vld),
    .src_tag   (src_tag),
    .rf_data   (rf_data),
    .opnd_data (opnd_data),
    .opnd_nrdy (opnd_nrdy)
);

// File: tb/clustered_bypass_tb.sv
module clustered_bypass_tb;

    localparam int N = 4, NSRC = 2, TW = 5, DW = 64, XD = 2, OPS = 8, LPC = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [N-1:0]             ex_vld, wb_vld;
    logic [N-1:0][TW-1:0]     ex_tag, wb_tag;
    logic [N-1:0][DW-1:0]     ex_data, wb_data;
    logic [OPS-1:0][TW-1:0]   src_tag;
    logic [OPS-1:0][DW-1:0]   rf_data, opnd_data;
    logic [OPS-1:0]           opnd_nrdy;

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    // history for the scoreboard: index 0 is the current execute stage
    logic            hv [0:XD][0:N-1];
    logic [TW-1:0]   ht [0:XD][0:N-1];
    logic [DW-1:0]   hd [0:XD][0:N-1];

    always #5 clk = ~clk;

    clustered_bypass u_dut (
        .clk(clk), .rst_n(rst_n),
        .ex_vld(ex_vld), .ex_tag(ex_tag), .ex_data(ex_data),
        .wb_vld(wb_vld), .wb_tag(wb_tag), .wb_data(wb_data),
        .src_tag(src_tag), .rf_data(rf_data),
        .opnd_data(opnd_data), .opnd_nrdy(opnd_nrdy)
    );

    task automatic chk(int op, logic [DW-1:0] ed, logic en, string req);
        n_chk++;
        if (opnd_data[op] !== ed || opnd_nrdy[op] !== en) begin
            n_err++;
            $display("FAIL %s op%0d: data=%h nrdy=%b expected data=%h nrdy=%b",
                     req, op, opnd_data[op], opnd_nrdy[op], ed, en);
        end
    endtask

    task automatic clear_prod();
        ex_vld = '0; ex_tag = '0; ex_data = '0;
        wb_vld = '0; wb_tag = '0; wb_data = '0;
    endtask

    task automatic set_rf();
        for (int o = 0; o < OPS; o++) begin
            src_tag[o] = TW'(20 + o);
            rf_data[o] = 64'hF000_0000_0000_0000 | 64'(o);
        end
    endtask

    task automatic idle(int n);
        clear_prod();
        set_rf();
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        // remote producer held during reset must leave nothing behind
        ex_vld = 4'b1000; ex_tag[3] = 5'd20; ex_data[3] = 64'hBAD;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        clear_prod();
        set_rf();
        #1;
        for (int o = 0; o < OPS; o++) chk(o, rf_data[o], 1'b0, "R1");
        @(negedge clk); #1;
        chk(0, rf_data[0], 1'b0, "R1");
    endtask

    task automatic t_local_ex();
        idle(3);
        ex_vld[1] = 1'b1; ex_tag[1] = 5'd7; ex_data[1] = 64'hA1;
        src_tag[0] = 5'd7; src_tag[2] = 5'd7; src_tag[4] = 5'd7; src_tag[5] = 5'd9;
        #1;
        chk(0, 64'hA1, 1'b0, "R2");
        chk(2, 64'hA1, 1'b0, "R2");
        chk(4, rf_data[4], 1'b1, "R5");
        chk(5, rf_data[5], 1'b0, "R7");
    endtask

    task automatic t_youngest();
        idle(3);
        ex_vld = 4'b0011; ex_tag[0] = 5'd3; ex_tag[1] = 5'd3;
        ex_data[0] = 64'hB0; ex_data[1] = 64'hB1;
        wb_vld = 4'b0011; wb_tag[0] = 5'd4; wb_tag[1] = 5'd4;
        wb_data[0] = 64'hC0; wb_data[1] = 64'hC1;
        src_tag[0] = 5'd3; src_tag[1] = 5'd4;
        #1;
        chk(0, 64'hB1, 1'b0, "R3");
        chk(1, 64'hC1, 1'b0, "R3");
        // execute beats writeback for the same tag
        wb_tag[1] = 5'd3;
        #1;
        chk(0, 64'hB1, 1'b0, "R2");
    endtask

    task automatic t_local_wb();
        idle(3);
        wb_vld[0] = 1'b1; wb_tag[0] = 5'd9; wb_data[0] = 64'hD0;
        src_tag[2] = 5'd9; src_tag[6] = 5'd9;
        #1;
        chk(2, 64'hD0, 1'b0, "R4");
        chk(6, rf_data[6], 1'b0, "R10");
    endtask

    task automatic t_remote_latency();
        idle(3);
        ex_vld[3] = 1'b1; ex_tag[3] = 5'd12; ex_data[3] = 64'hE3;
        src_tag[0] = 5'd12;
        #1; chk(0, rf_data[0], 1'b1, "R5");
        @(negedge clk);
        clear_prod();
        wb_vld[3] = 1'b1; wb_tag[3] = 5'd12; wb_data[3] = 64'hE3;
        #1; chk(0, rf_data[0], 1'b1, "R6");
        @(negedge clk);
        clear_prod();
        #1; chk(0, 64'hE3, 1'b0, "R6");
        @(negedge clk);
        #1; chk(0, rf_data[0], 1'b0, "R6");
    endtask

    task automatic t_orders();
        idle(3);
        // remote execute beats local writeback
        ex_vld[2] = 1'b1; ex_tag[2] = 5'd5; ex_data[2] = 64'h52;
        wb_vld[0] = 1'b1; wb_tag[0] = 5'd5; wb_data[0] = 64'h50;
        src_tag[0] = 5'd5;
        #1; chk(0, rf_data[0], 1'b1, "R5");
        idle(3);
        ex_vld[2] = 1'b1; ex_tag[2] = 5'd6; ex_data[2] = 64'h62;
        @(negedge clk);
        clear_prod();
        wb_vld[0] = 1'b1; wb_tag[0] = 5'd6; wb_data[0] = 64'h60;
        src_tag[2] = 5'd6;
        #1; chk(2, 64'h60, 1'b0, "R8");
        idle(3);
        // local execute beats a visible remote result
        ex_vld[3] = 1'b1; ex_tag[3] = 5'd8; ex_data[3] = 64'h83;
        @(negedge clk); clear_prod();
        @(negedge clk);
        ex_vld[1] = 1'b1; ex_tag[1] = 5'd8; ex_data[1] = 64'h81;
        src_tag[0] = 5'd8; src_tag[1] = 5'd8;
        #1;
        chk(0, 64'h81, 1'b0, "R2");
        ex_vld[1] = 1'b0;
        #1;
        chk(1, 64'h83, 1'b0, "R6");
    endtask

    task automatic t_invalid_and_own();
        idle(3);
        ex_tag[0] = 5'd10; ex_data[0] = 64'h10; ex_tag[3] = 5'd10; ex_data[3] = 64'h13;
        wb_tag[1] = 5'd10; wb_data[1] = 64'h11;
        src_tag[2] = 5'd10;
        #1; chk(2, rf_data[2], 1'b0, "R9");
        @(negedge clk); #1; chk(2, rf_data[2], 1'b0, "R9");
        @(negedge clk); #1; chk(2, rf_data[2], 1'b0, "R9");
        idle(3);
        ex_vld[0] = 1'b1; ex_tag[0] = 5'd11; ex_data[0] = 64'h1100;
        src_tag[2] = 5'd11;
        #1; chk(2, 64'h1100, 1'b0, "R2");
        @(negedge clk); clear_prod(); #1; chk(2, rf_data[2], 1'b0, "R10");
        @(negedge clk); #1; chk(2, rf_data[2], 1'b0, "R10");
    endtask

    function automatic void model(int op, output logic [DW-1:0] ed, output logic en);
        int  cl = (op / NSRC) / LPC;
        logic hit = 1'b0;
        ed = rf_data[op]; en = 1'b0;
        for (int j = 0; j < N; j++)
            if (j / LPC == cl && hv[0][j] && ht[0][j] == src_tag[op]) begin hit = 1'b1; ed = hd[0][j]; end
        if (hit) return;
        for (int j = 0; j < N; j++)
            if (j / LPC != cl && hv[0][j] && ht[0][j] == src_tag[op]) begin en = 1'b1; return; end
        for (int j = 0; j < N; j++)
            if (j / LPC == cl && hv[1][j] && ht[1][j] == src_tag[op]) begin hit = 1'b1; ed = hd[1][j]; end
        if (hit) return;
        for (int a = 1; a <= XD; a++) begin
            logic [DW-1:0] v = '0;
            for (int j = 0; j < N; j++)
                if (j / LPC != cl && hv[a][j] && ht[a][j] == src_tag[op]) begin hit = 1'b1; v = hd[a][j]; end
            if (hit) begin
                if (a == XD) ed = v; else en = 1'b1;
                return;
            end
        end
    endfunction

    task automatic t_random();
        logic [DW-1:0] ed;
        logic en;
        idle(4);
        for (int a = 0; a <= XD; a++)
            for (int j = 0; j < N; j++) begin hv[a][j] = 1'b0; ht[a][j] = '0; hd[a][j] = '0; end
        for (int cyc = 0; cyc < 300; cyc++) begin
            @(negedge clk);
            for (int j = 0; j < N; j++) begin
                ex_vld[j]  = $urandom_range(0, 1) == 1;
                ex_tag[j]  = TW'($urandom_range(0, 3));
                ex_data[j] = {$urandom, $urandom};
                hv[0][j] = ex_vld[j]; ht[0][j] = ex_tag[j]; hd[0][j] = ex_data[j];
                wb_vld[j] = hv[1][j]; wb_tag[j] = ht[1][j]; wb_data[j] = hd[1][j];
            end
            for (int o = 0; o < OPS; o++) begin
                src_tag[o] = TW'($urandom_range(0, 4));
                rf_data[o] = {$urandom, $urandom};
            end
            #1;
            for (int o = 0; o < OPS; o++) begin
                model(o, ed, en);
                chk(o, ed, en, "R3/scoreboard R6");
            end
            @(posedge clk);
            for (int a = XD; a >= 1; a--)
                for (int j = 0; j < N; j++) begin
                    hv[a][j] = hv[a-1][j]; ht[a][j] = ht[a-1][j]; hd[a][j] = hd[a-1][j];
                end
        end
    endtask

    initial begin
        clear_prod();
        set_rf();
        @(negedge clk);
        t_reset();
        t_local_ex();
        t_youngest();
        t_local_wb();
        t_remote_latency();
        t_orders();
        t_invalid_and_own();
        t_random();
        idle(2);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_err++; n_chk++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule